// File: doc/BRIEF.md
# Scratchpad Chain DMA Channel

This block is one DMA channel that moves 128-bit quadwords between main memory and a 16 KiB on-chip scratchpad. Software-equivalent register values are presented on the start inputs, and `start` launches the channel. In normal mode the channel moves the loaded count of quadwords and stops. In chain mode it first moves any loaded count. It then repeatedly fetches a 128-bit tag, decodes the tag's count, kind, interrupt request and data address, and moves that payload. After each payload it either fetches the next tag or ends.

The direction input picks one of two sources for tags. When data flows into the scratchpad, tags are read from main memory at the tag address. Each tag can optionally be copied into the scratchpad ahead of its payload. When data flows out of the scratchpad, tags sit inline in the scratchpad stream. On that outbound path, main-memory addresses can be folded into a ring buffer, and a stall address can be captured from counted-with-stall tags. Both memories are modelled behind a simple single-cycle request interface: read data is returned in the same cycle as the request, and writes take effect at the clock edge.

Top module: `chain_dma`

## Requirements
- R1: In normal mode (`ctrlIn[3:2]` = 2'b00), `start` moves `qwcIn` quadwords, one per cycle. Both addresses step by 16 per quadword. Control bit 8 reads 1 while busy. At the end, bit 8 is cleared, the count reads 0, and `irq` pulses high for exactly one cycle as `busy` falls.
- R2: `dirToSp`=1 copies main memory at `madr` into the scratchpad at `sadr`. `dirToSp`=0 copies the scratchpad into main memory. The scratchpad uses only the low 14 address bits.
- R3: In chain mode (`ctrlIn[3:2]` = 2'b01), each tag is decoded with the count in bits [15:0], the kind in [30:28], the interrupt request in bit 31 and the data address in [63:32]. Tag bits [31:16] are copied into control bits [31:16], while control bits [15:0] are kept, except bit 8 at the end.
- R4: On the outbound path (`dirToSp`=0), the tag is read from the scratchpad at `sadr`, and `sadr` advances by 16 before its payload is read.
- R5: On the inbound path (`dirToSp`=1), the tag is read from main memory at `tadr`. For kinds 0 and 1 the next tag address becomes data address + 16 × count. With control bit 6 set, the tag itself is first written to the scratchpad at `sadr`, which advances by 16.
- R6: Kind 7 ends the chain after its payload, and kind 1 continues. A tag with a zero count moves nothing but is still decoded.
- R7: A kind-0 tag continues the chain and, when `stallSel` = 2'b10, loads its data address into `stallAddr`.
- R8: With control bit 7 set, a tag whose bit 31 is 1 ends the chain after its payload. With bit 7 clear, the chain continues.
- R9: If `memErr` is high on an inbound tag read, the chain ends without decoding the tag, `busErr` is set, and `irq` still pulses.
- R10: A tag kind other than 0, 1 or 7 ends the chain with no payload moved, sets `idErr` and leaves the count at 0.
- R11: On the outbound path with `ringSel[1]`=1, each quadword sets `madr` to `ringBase` + ((`madr` + 16) AND `ringMask`).
- R12: While idle, neither memory is requested. Both memories are never written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse, taken when idle |
| dirToSp | input | 1 | 1: main memory to scratchpad; 0: scratchpad to main memory |
| ctrlIn | input | 32 | Initial channel control word |
| madrIn | input | 32 | Initial main-memory data address |
| sadrIn | input | 32 | Initial scratchpad address |
| tadrIn | input | 32 | Initial tag address (inbound path) |
| qwcIn | input | 16 | Initial quadword count |
| stallSel | input | 2 | Stall source select; 2'b10 enables stall capture |
| ringSel | input | 2 | Ring mode select; bit 1 enables wrapping |
| ringBase | input | 32 | Ring buffer base address |
| ringMask | input | 32 | Ring buffer size mask |
| memReq | output | 1 | Main-memory request |
| memWe | output | 1 | Main-memory write enable |
| memAddr | output | 32 | Main-memory byte address |
| memWdata | output | 128 | Main-memory write data |
| memRdata | input | 128 | Main-memory read data (same cycle) |
| memErr | input | 1 | Main-memory address invalid |
| spReq | output | 1 | Scratchpad request |
| spWe | output | 1 | Scratchpad write enable |
| spAddr | output | 14 | Scratchpad byte address |
| spWdata | output | 128 | Scratchpad write data |
| spRdata | input | 128 | Scratchpad read data (same cycle) |
| busy | output | 1 | Channel active |
| ctrlOut | output | 32 | Current control word |
| madrOut | output | 32 | Current data address |
| sadrOut | output | 32 | Current scratchpad address |
| tadrOut | output | 32 | Current tag address |
| qwcOut | output | 16 | Remaining quadword count |
| stallAddr | output | 32 | Captured stall address |
| busErr | output | 1 | Tag read hit an invalid address |
| idErr | output | 1 | Unsupported tag kind seen |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Normal-mode transfers are tried in both directions with counts of zero, one and several. One case places the scratchpad address at the top of its 14-bit space, so that a wrong direction, wrong stepping or a missing wrap shows up as misplaced data. Chain runs use inbound tags with tag forwarding, where a kind-1 tag is followed by a kind-7 tag. They also use outbound inline tags with ring folding and stall capture. Comparing the final addresses and mirrored control bits separates a chain that continued from one that stopped. Paired runs of the same tag with the interrupt enable set and cleared isolate the early stop. An out-of-range tag address and an unknown kind exercise the two error exits.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int QW_BYTES  = 16;
  localparam int START_BIT = 8;
  localparam int TTE_BIT   = 6;
  localparam int TIE_BIT   = 7;

  localparam logic [2:0] KIND_CNTS = 3'd0;
  localparam logic [2:0] KIND_CNT  = 3'd1;
  localparam logic [2:0] KIND_END  = 3'd7;

  typedef struct packed {
    logic load;
    logic fetchTag;
    logic moveBeat;
    logic finish;
  } dma_strobe_t;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAG, S_DONE} dma_state_t;
endpackage

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startChain,
  input  logic        qwcZero,
  input  logic        tagFault,
  input  logic [2:0]  tagKind,
  input  logic        tagIrq,
  input  logic        tieOn,
  output dma_strobe_t st,
  output logic        busy
);
  dma_state_t state, nxt;
  logic lastFlag;
  logic kindKnown;

  assign kindKnown = (tagKind == KIND_CNTS) || (tagKind == KIND_CNT) || (tagKind == KIND_END);
  assign busy = (state != S_IDLE);

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        st.load = 1'b1;
        nxt = S_XFER;
      end
      S_XFER: begin
        if (!qwcZero) st.moveBeat = 1'b1;
        else if (lastFlag) nxt = S_DONE;
        else nxt = S_TAG;
      end
      S_TAG: begin
        st.fetchTag = 1'b1;
        nxt = (tagFault || !kindKnown) ? S_DONE : S_XFER;
      end
      default: begin
        st.finish = 1'b1;
        nxt = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      lastFlag <= 1'b1;
    end else begin
      state <= nxt;
      if (st.load) lastFlag <= !startChain;
      else if (state == S_TAG) lastFlag <= (tagKind == KIND_END) || (tieOn && tagIrq);
    end
  end
endmodule

// File: rtl/chain_dma_path.sv
module chain_dma_path
  import chain_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 128,
  parameter int SP_AW = 14,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dma_strobe_t      st,
  input  logic             dirIn,
  input  logic [31:0]      ctrlIn,
  input  logic [AW-1:0]    madrIn,
  input  logic [AW-1:0]    sadrIn,
  input  logic [AW-1:0]    tadrIn,
  input  logic [CW-1:0]    qwcIn,
  input  logic [1:0]       stallSel,
  input  logic [1:0]       ringSel,
  input  logic [AW-1:0]    ringBase,
  input  logic [AW-1:0]    ringMask,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  input  logic             memErr,
  output logic             spReq,
  output logic             spWe,
  output logic [SP_AW-1:0] spAddr,
  output logic [DW-1:0]    spWdata,
  input  logic [DW-1:0]    spRdata,
  output logic [31:0]      ctrl,
  output logic [AW-1:0]    madr,
  output logic [AW-1:0]    sadr,
  output logic [AW-1:0]    tadr,
  output logic [CW-1:0]    qwc,
  output logic [AW-1:0]    stallAddr,
  output logic             busErr,
  output logic             idErr,
  output logic             irq,
  output logic             qwcZero,
  output logic             tagFault,
  output logic [2:0]       tagKind,
  output logic             tagIrq,
  output logic             tieOn
);
  localparam logic [AW-1:0] STEP = AW'(QW_BYTES);
  localparam int SHIFT = $clog2(QW_BYTES);

  logic          dirReg;
  logic [DW-1:0] tagWord;
  logic [CW-1:0] tagCount;
  logic [AW-1:0] tagAddr;
  logic          tagTake;
  logic          wrapOn;
  logic [AW-1:0] madrStep;

  assign tagWord  = dirReg ? memRdata : spRdata;
  assign tagCount = tagWord[CW-1:0];
  assign tagKind  = tagWord[30:28];
  assign tagIrq   = tagWord[31];
  assign tagAddr  = tagWord[32 +: AW];
  assign tagFault = dirReg && memErr;
  assign tagTake  = st.fetchTag && !tagFault;
  assign qwcZero  = (qwc == '0);
  assign tieOn    = ctrl[TIE_BIT];
  assign wrapOn   = !dirReg && ringSel[1];
  assign madrStep = wrapOn ? ringBase + ((madr + STEP) & ringMask) : madr + STEP;

  always_comb begin
    memReq = 1'b0; memWe = 1'b0; memAddr = madr; memWdata = '0;
    spReq  = 1'b0; spWe  = 1'b0; spAddr = sadr[SP_AW-1:0]; spWdata = '0;
    if (st.fetchTag) begin
      if (dirReg) begin
        memReq  = 1'b1;
        memAddr = tadr;
        if (ctrl[TTE_BIT]) begin
          spReq   = 1'b1;
          spWe    = 1'b1;
          spWdata = memRdata;
        end
      end else begin
        spReq = 1'b1;
      end
    end
    if (st.moveBeat) begin
      memReq = 1'b1;
      spReq  = 1'b1;
      if (dirReg) begin
        spWe    = 1'b1;
        spWdata = memRdata;
      end else begin
        memWe    = 1'b1;
        memWdata = spRdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= 1'b0; ctrl <= '0; madr <= '0; sadr <= '0; tadr <= '0;
      qwc <= '0; stallAddr <= '0; busErr <= 1'b0; idErr <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= st.finish;
      if (st.load) begin
        dirReg <= dirIn;
        ctrl   <= ctrlIn | (32'd1 << START_BIT);
        madr   <= madrIn;
        sadr   <= sadrIn;
        tadr   <= tadrIn;
        qwc    <= qwcIn;
        busErr <= 1'b0;
        idErr  <= 1'b0;
      end
      if (st.fetchTag && tagFault) busErr <= 1'b1;
      if (tagTake) begin
        ctrl[31:16] <= tagWord[31:16];
        qwc  <= tagCount;
        madr <= tagAddr;
        if (!dirReg || ctrl[TTE_BIT]) sadr <= sadr + STEP;
        if (dirReg && (tagKind == KIND_CNT || tagKind == KIND_CNTS))
          tadr <= tagAddr + (AW'(tagCount) << SHIFT);
        if (tagKind == KIND_CNTS && stallSel == 2'b10) stallAddr <= tagAddr;
        if (tagKind != KIND_CNTS && tagKind != KIND_CNT && tagKind != KIND_END) idErr <= 1'b1;
      end
      if (st.moveBeat) begin
        qwc  <= qwc - 1'b1;
        sadr <= sadr + STEP;
        madr <= madrStep;
      end
      if (st.finish) begin
        ctrl[START_BIT] <= 1'b0;
        qwc <= '0;
      end
    end
  end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 128,
  parameter int SP_AW = 14,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirToSp,
  input  logic [31:0]      ctrlIn,
  input  logic [AW-1:0]    madrIn,
  input  logic [AW-1:0]    sadrIn,
  input  logic [AW-1:0]    tadrIn,
  input  logic [CW-1:0]    qwcIn,
  input  logic [1:0]       stallSel,
  input  logic [1:0]       ringSel,
  input  logic [AW-1:0]    ringBase,
  input  logic [AW-1:0]    ringMask,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  input  logic             memErr,
  output logic             spReq,
  output logic             spWe,
  output logic [SP_AW-1:0] spAddr,
  output logic [DW-1:0]    spWdata,
  input  logic [DW-1:0]    spRdata,
  output logic             busy,
  output logic [31:0]      ctrlOut,
  output logic [AW-1:0]    madrOut,
  output logic [AW-1:0]    sadrOut,
  output logic [AW-1:0]    tadrOut,
  output logic [CW-1:0]    qwcOut,
  output logic [AW-1:0]    stallAddr,
  output logic             busErr,
  output logic             idErr,
  output logic             irq
);
  dma_strobe_t st;
  logic qwcZero, tagFault, tagIrq, tieOn;
  logic [2:0] tagKind;

  chain_dma_ctrl u_ctrl (
    .clk, .rstN, .start,
    .startChain(ctrlIn[3:2] == 2'b01),
    .qwcZero, .tagFault, .tagKind, .tagIrq, .tieOn,
    .st, .busy
  );

  chain_dma_path #(.AW(AW), .DW(DW), .SP_AW(SP_AW), .CW(CW)) u_path (
    .clk, .rstN, .st, .dirIn(dirToSp), .ctrlIn, .madrIn, .sadrIn, .tadrIn, .qwcIn,
    .stallSel, .ringSel, .ringBase, .ringMask,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memErr,
    .spReq, .spWe, .spAddr, .spWdata, .spRdata,
    .ctrl(ctrlOut), .madr(madrOut), .sadr(sadrOut), .tadr(tadrOut), .qwc(qwcOut),
    .stallAddr, .busErr, .idErr, .irq,
    .qwcZero, .tagFault, .tagKind, .tagIrq, .tieOn
  );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        irq,
  input logic [31:0] ctrlOut,
  input logic        memReq,
  input logic        memWe,
  input logic        spReq,
  input logic        spWe,
  input logic        memErr,
  input logic        busErr
);
  // R1
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq);
  // R1
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> irq);
  // R1
  start_bit_clear_chk: assert property (@(posedge clk) disable iff (!rstN) irq |-> !ctrlOut[8]);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (!memReq && !spReq));
  // R12
  one_writer_chk: assert property (@(posedge clk) disable iff (!rstN) !((memReq && memWe) && (spReq && spWe)));
  // R9
  bus_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErr) |-> $past(memErr && memReq && !memWe));
endmodule

bind chain_dma chain_dma_chk u_chk (
  .clk, .rstN, .busy, .irq, .ctrlOut, .memReq, .memWe, .spReq, .spWe, .memErr, .busErr
);

// File: tb/test_chain_dma.sv
module test_chain_dma;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0, dirToSp = 1'b0;
  logic [31:0] ctrlIn = '0, madrIn = '0, sadrIn = '0, tadrIn = '0;
  logic [15:0] qwcIn = '0;
  logic [1:0] stallSel = '0, ringSel = '0;
  logic [31:0] ringBase = '0, ringMask = '0;
  logic memReq, memWe, memErr, spReq, spWe;
  logic [31:0] memAddr;
  logic [127:0] memWdata, memRdata, spWdata, spRdata;
  logic [13:0] spAddr;
  logic busy, busErr, idErr, irq;
  logic [31:0] ctrlOut, madrOut, sadrOut, tadrOut, stallAddr;
  logic [15:0] qwcOut;

  chain_dma i_chain_dma (.*);

  logic [127:0] mainMem [64];
  logic [127:0] spMem [1024];
  assign memRdata = mainMem[memAddr[9:4]];
  assign memErr   = memReq && !memWe && (memAddr >= 32'h400);
  assign spRdata  = spMem[spAddr[13:4]];
  always @(posedge clk) begin
    if (memReq && memWe) mainMem[memAddr[9:4]] <= memWdata;
    if (spReq && spWe) spMem[spAddr[13:4]] <= spWdata;
  end

  int checks = 0, fails = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(int a, int b);
    return {32'(a), 32'(b), 32'hC0DE0000 + 32'(a * 16 + b), ~32'(b)};
  endfunction

  function automatic logic [127:0] tag(logic irqB, logic [2:0] kind, logic [15:0] cnt, logic [31:0] addr);
    return {64'hFACE_0000_0000_BEEF, addr, irqB, kind, 12'h000, cnt};
  endfunction

  task automatic runDma(logic dir, logic [31:0] c, logic [31:0] ma, logic [31:0] sa,
                        logic [31:0] ta, logic [15:0] q);
    int w;
    @(negedge clk);
    dirToSp = dir; ctrlIn = c; madrIn = ma; sadrIn = sa; tadrIn = ta; qwcIn = q;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 start bit while busy", 128'(ctrlOut[8]), 128'd1);
    w = 0;
    while (busy && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk("R1 irq at end", 128'(irq), 128'd1);
    chk("R1 count zero at end", 128'(qwcOut), 128'd0);
    @(negedge clk);
    chk("R1 irq one cycle", 128'(irq), 128'd0);
  endtask

  typedef struct packed {
    logic        dir;
    logic [15:0] cnt;
    logic [31:0] madr;
    logic [31:0] sadr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 16'd3, 32'h000, 32'h0100},
    '{1'b0, 16'd2, 32'h040, 32'h0200},
    '{1'b1, 16'd1, 32'h3F0, 32'h3FF0},
    '{1'b0, 16'd4, 32'h080, 32'h0000},
    '{1'b1, 16'd0, 32'h000, 32'h0300}
  };

  initial begin
    for (int i = 0; i < 64; i++) mainMem[i] = '0;
    for (int i = 0; i < 1024; i++) spMem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 128'(busy), 128'd0);
    chk("R1 reset irq", 128'(irq), 128'd0);
    chk("R3 reset ctrl", 128'(ctrlOut), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 idle no request", 128'({memReq, spReq}), 128'd0);

    // R1 R2 normal mode table
    for (int v = 0; v < 5; v++) begin
      for (int k = 0; k < int'(VECS[v].cnt); k++) begin
        if (VECS[v].dir) begin
          mainMem[(int'(VECS[v].madr) >> 4) + k] = pat(v, k);
          spMem[((int'(VECS[v].sadr) >> 4) + k) % 1024] = '0;
        end else begin
          spMem[(int'(VECS[v].sadr) >> 4) + k] = pat(v, k);
          mainMem[(int'(VECS[v].madr) >> 4) + k] = '0;
        end
      end
      runDma(VECS[v].dir, 32'h0, VECS[v].madr, VECS[v].sadr, 32'h0, VECS[v].cnt);
      for (int k = 0; k < int'(VECS[v].cnt); k++) begin
        if (VECS[v].dir)
          chk("R2 to scratchpad data", spMem[((int'(VECS[v].sadr) >> 4) + k) % 1024], pat(v, k));
        else
          chk("R2 to memory data", mainMem[(int'(VECS[v].madr) >> 4) + k], pat(v, k));
      end
      chk("R1 madr step", 128'(madrOut), 128'(VECS[v].madr + 32'(VECS[v].cnt) * 16));
      chk("R1 sadr step", 128'(sadrOut), 128'(VECS[v].sadr + 32'(VECS[v].cnt) * 16));
      chk("R1 ctrl after", 128'(ctrlOut), 128'd0);
    end

    // R3 R5 R6 inbound chain with tag forwarding
    mainMem[0]  = tag(1'b0, 3'd1, 16'd2, 32'h100);
    mainMem[16] = pat(20, 0);
    mainMem[17] = pat(20, 1);
    mainMem[18] = tag(1'b0, 3'd7, 16'd1, 32'h200);
    mainMem[32] = pat(20, 2);
    runDma(1'b1, 32'h44, 32'h0, 32'h40, 32'h0, 16'd0);
    chk("R5 forwarded tag0", spMem[4], tag(1'b0, 3'd1, 16'd2, 32'h100));
    chk("R5 payload0", spMem[5], pat(20, 0));
    chk("R5 payload1", spMem[6], pat(20, 1));
    chk("R5 forwarded tag1", spMem[7], tag(1'b0, 3'd7, 16'd1, 32'h200));
    chk("R6 end payload", spMem[8], pat(20, 2));
    chk("R5 next tag address", 128'(tadrOut), 128'h120);
    chk("R3 ctrl mirror", 128'(ctrlOut), 128'h7000_0044);
    chk("R6 madr after end", 128'(madrOut), 128'h210);
    chk("R5 sadr", 128'(sadrOut), 128'h90);

    // R4 R7 R11 outbound chain with ring and stall capture
    spMem[0] = tag(1'b0, 3'd0, 16'd2, 32'h380);
    spMem[1] = pat(30, 0);
    spMem[2] = pat(30, 1);
    spMem[3] = tag(1'b0, 3'd7, 16'd1, 32'h3F0);
    spMem[4] = pat(30, 2);
    stallSel = 2'b10; ringSel = 2'b10; ringBase = 32'h300; ringMask = 32'hFF;
    runDma(1'b0, 32'h04, 32'h0, 32'h0, 32'h0, 16'd0);
    chk("R4 payload0", mainMem[56], pat(30, 0));
    chk("R11 payload1", mainMem[57], pat(30, 1));
    chk("R11 payload2", mainMem[63], pat(30, 2));
    chk("R11 wrapped madr", 128'(madrOut), 128'h300);
    chk("R7 stall addr", 128'(stallAddr), 128'h380);
    chk("R4 sadr", 128'(sadrOut), 128'h50);
    stallSel = 2'b00; ringSel = 2'b00;

    // R8 interrupt stop vs continue
    mainMem[0]  = tag(1'b1, 3'd1, 16'd1, 32'h100);
    mainMem[16] = pat(40, 0);
    mainMem[17] = tag(1'b0, 3'd7, 16'd0, 32'h300);
    runDma(1'b1, 32'h84, 32'h0, 32'h600, 32'h0, 16'd0);
    chk("R8 stopped ctrl", 128'(ctrlOut), 128'h9000_0084);
    chk("R8 stopped payload", spMem[96], pat(40, 0));
    chk("R8 stopped madr", 128'(madrOut), 128'h110);
    runDma(1'b1, 32'h04, 32'h0, 32'h600, 32'h0, 16'd0);
    chk("R8 continued ctrl", 128'(ctrlOut), 128'h7000_0004);
    chk("R6 zero count end decoded", 128'(madrOut), 128'h300);
    chk("R6 zero count sadr", 128'(sadrOut), 128'h610);

    // R9 bus error
    runDma(1'b1, 32'h04, 32'h0, 32'h0, 32'h800, 16'd0);
    chk("R9 bus error", 128'(busErr), 128'd1);
    chk("R9 ctrl untouched", 128'(ctrlOut), 128'h0000_0004);

    // R10 unsupported kind
    mainMem[0] = tag(1'b0, 3'd3, 16'd1, 32'h100);
    spMem[80] = '0;
    runDma(1'b1, 32'h04, 32'h0, 32'h500, 32'h0, 16'd0);
    chk("R10 id error", 128'(idErr), 128'd1);
    chk("R10 no payload", spMem[80], 128'd0);
    chk("R10 bus error clear", 128'(busErr), 128'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule